// File: doc/BRIEF.md
# Polled Keyboard Port Controller

This block is a small peripheral that a processor reaches with ordinary load and store accesses inside an eight-byte window. On the device side it receives scancode bytes through a simple valid/byte input. It holds the most recent accepted byte until the host has consumed it. A ready flag in the status byte tells polling software when a fresh byte is waiting. Reading the data location hands the byte over and clears that flag.

The host steers the block by writing command codes. One code runs a self-test that leaves a fixed pass byte waiting for the host. Another code lets the keyboard deliver scancodes. A third code arms the block so that the following data write sets a three-bit LED output. Scancodes that arrive while the keyboard is disabled are thrown away. A scancode that arrives while the previous one is still unread is dropped, and an overrun flag records the loss.

Top module: `scan_port`

## Requirements
- R1: After reset the status byte reads 0x00, the keyboard is disabled, no LED parameter is pending and `ledOut` is 0.
- R2: Byte offset 0 is the status/command location and byte offset 4 is the data location. Reads at offsets 1, 2, 3, 5, 6 and 7 return 0x00, and writes there change nothing.
- R3: The status byte is laid out as bit 0 ready, bit 1 overrun, bit 2 keyboard enabled and bit 3 LED parameter pending, with bits 7:4 always zero. A read at offset 0 returns this byte.
- R4: While the keyboard is enabled, a scancode that arrives when the ready flag is clear (or is being cleared in that same cycle) is stored as the data byte, and the ready flag reads 1 from the next cycle on.
- R5: A read at offset 4 returns the stored byte in the same cycle and clears the ready flag at that clock edge. If a scancode is accepted in that same cycle, the ready flag stays 1 and the new byte replaces the old one.
- R6: While the keyboard is disabled, incoming scancodes change neither the data byte nor any status bit.
- R7: While the keyboard is enabled, a scancode that arrives when the ready flag is set and no data read takes place is dropped, and the overrun flag is set. A status read clears the overrun flag, unless a new drop occurs in that same cycle, in which case the set wins.
- R8: Writing command 0xAE to offset 0 enables the keyboard from the next cycle on.
- R9: Writing command 0xAA to offset 0 places 0x55 in the data byte and sets the ready flag. It also clears the overrun and LED-pending flags and disables the keyboard. A scancode arriving in that cycle is discarded.
- R10: Writing command 0xED to offset 0 sets the LED-pending flag. The next write to offset 4 copies bits 2:0 of the written byte to `ledOut` and clears the pending flag.
- R11: A write to offset 4 while no LED parameter is pending leaves `ledOut` and the status byte unchanged.
- R12: A write at offset 0 of any code other than 0xAA, 0xAE or 0xED leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Host access valid this cycle |
| busWrite | input | 1 | 1 = store, 0 = load |
| busAddr | input | 3 | Byte offset inside the window |
| busWdata | input | 8 | Store data |
| busRdata | output | 8 | Load data, valid in the access cycle |
| keyValid | input | 1 | A scancode byte is offered this cycle |
| keyCode | input | 8 | Offered scancode byte |
| ledOut | output | 3 | Latched LED state |

## Verification
The properties assume that `busSel`, `busWrite`, `busAddr`, `busWdata`, `keyValid` and `keyCode` hold steady between clock edges. They also assume that a host access takes exactly one cycle, so a single read at offset 4 consumes the ready flag only once. The stimulus changes every input at the falling edge and issues each access as a single-cycle pulse. Alongside its directed sequences, the bench runs a random phase that mixes scancode arrivals with reads, writes and command codes in the same cycles. This exercises the collision orderings (read against arrival, status read against drop, self-test against arrival) that the properties single out.

// File: rtl/scan_port_pkg.sv
`timescale 1ns/1ps
package scan_port_pkg;
  localparam logic [7:0] CMD_SELFTEST  = 8'hAA;
  localparam logic [7:0] CMD_ENABLE    = 8'hAE;
  localparam logic [7:0] CMD_LEDSET    = 8'hED;
  localparam logic [7:0] SELFTEST_PASS = 8'h55;
  localparam int OFS_STATUS = 0;
  localparam int OFS_DATA   = 4;
  localparam int BIT_READY  = 0;
  localparam int BIT_OVER   = 1;
  localparam int BIT_EN     = 2;
  localparam int BIT_PEND   = 3;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic statusRead;
    logic dataRead;
    logic selfTest;
    logic ledLoad;
    logic keyAccept;
    logic keyDrop;
  } strobe_t;
endpackage

// File: rtl/scan_port_ctrl.sv
`timescale 1ns/1ps
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              keyValid,
  input  logic              readyFlag,
  output strobe_t           strobe,
  output logic              enabledFlag,
  output logic              ledPendFlag
);
  localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] DATA_OFS   = ADDR_W'(OFS_DATA);

  logic hitStatus, hitData;
  logic cmdWrite, dataWrite;
  logic isSelfTest, isEnable, isLedSet;
  logic readyAfterRead;
  logic enabledQ, pendQ;

  assign hitStatus = busSel && (busAddr == STATUS_OFS);
  assign hitData   = busSel && (busAddr == DATA_OFS);
  assign cmdWrite  = hitStatus && busWrite;
  assign dataWrite = hitData && busWrite;

  assign isSelfTest = cmdWrite && (busWdata == DATA_W'(CMD_SELFTEST));
  assign isEnable   = cmdWrite && (busWdata == DATA_W'(CMD_ENABLE));
  assign isLedSet   = cmdWrite && (busWdata == DATA_W'(CMD_LEDSET));

  // a data read in this cycle frees the holding byte for an arrival
  assign readyAfterRead = readyFlag && !(hitData && !busWrite);

  always_comb begin
    strobe            = '0;
    strobe.statusRead = hitStatus && !busWrite;
    strobe.dataRead   = hitData && !busWrite;
    strobe.selfTest   = isSelfTest;
    strobe.ledLoad    = dataWrite && pendQ;
    strobe.keyAccept  = keyValid && enabledQ && !readyAfterRead && !isSelfTest;
    strobe.keyDrop    = keyValid && enabledQ && readyAfterRead && !isSelfTest;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enabledQ <= 1'b0;
      pendQ    <= 1'b0;
    end else begin
      if (isSelfTest) begin
        enabledQ <= 1'b0;
        pendQ    <= 1'b0;
      end else begin
        if (isEnable) enabledQ <= 1'b1;
        if (isLedSet) pendQ <= 1'b1;
        else if (dataWrite && pendQ) pendQ <= 1'b0;
      end
    end
  end

  assign enabledFlag = enabledQ;
  assign ledPendFlag = pendQ;
endmodule

// File: rtl/scan_port_dp.sv
`timescale 1ns/1ps
module scan_port_dp
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int LED_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] keyCode,
  input  logic              enabledFlag,
  input  logic              ledPendFlag,
  output logic [DATA_W-1:0] busRdata,
  output logic              readyFlag,
  output logic              overrunFlag,
  output logic [LED_W-1:0]  ledOut
);
  localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] DATA_OFS   = ADDR_W'(OFS_DATA);

  logic [DATA_W-1:0] dataQ;
  logic              readyQ, overQ;
  logic [LED_W-1:0]  ledQ;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      readyQ <= 1'b0;
      overQ  <= 1'b0;
      ledQ   <= '0;
    end else begin
      if (strobe.selfTest) begin
        dataQ  <= DATA_W'(SELFTEST_PASS);
        readyQ <= 1'b1;
        overQ  <= 1'b0;
      end else begin
        if (strobe.keyAccept) begin
          dataQ  <= keyCode;
          readyQ <= 1'b1;
        end else if (strobe.dataRead) begin
          readyQ <= 1'b0;
        end
        if (strobe.keyDrop) overQ <= 1'b1;
        else if (strobe.statusRead) overQ <= 1'b0;
      end
      if (strobe.ledLoad) ledQ <= busWdata[LED_W-1:0];
    end
  end

  always_comb begin
    statusByte            = '0;
    statusByte[BIT_READY] = readyQ;
    statusByte[BIT_OVER]  = overQ;
    statusByte[BIT_EN]    = enabledFlag;
    statusByte[BIT_PEND]  = ledPendFlag;
  end

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      if (busAddr == STATUS_OFS)    busRdata = statusByte;
      else if (busAddr == DATA_OFS) busRdata = dataQ;
    end
  end

  assign readyFlag   = readyQ;
  assign overrunFlag = overQ;
  assign ledOut      = ledQ;
endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int LED_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              keyValid,
  input  logic [DATA_W-1:0] keyCode,
  output logic [LED_W-1:0]  ledOut
);
  strobe_t strobe;
  logic    readyFlag, overrunFlag, enabledFlag, ledPendFlag;

  scan_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .keyValid(keyValid),
    .readyFlag(readyFlag), .strobe(strobe),
    .enabledFlag(enabledFlag), .ledPendFlag(ledPendFlag)
  );

  scan_port_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .keyCode(keyCode), .enabledFlag(enabledFlag), .ledPendFlag(ledPendFlag),
    .busRdata(busRdata), .readyFlag(readyFlag), .overrunFlag(overrunFlag),
    .ledOut(ledOut)
  );
endmodule

// File: rtl/scan_port_checker.sv
`timescale 1ns/1ps
module scan_port_checker
  import scan_port_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int LED_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              keyValid,
  input logic [LED_W-1:0]  ledOut,
  input logic              readyFlag,
  input logic              overrunFlag,
  input logic              enabledFlag,
  input logic              ledPendFlag
);
  logic atStatus, atData, stsRd, datRd, cmdWr, datWr, padRd;
  assign atStatus = busAddr == ADDR_W'(OFS_STATUS);
  assign atData   = busAddr == ADDR_W'(OFS_DATA);
  assign stsRd = busSel && !busWrite && atStatus;
  assign datRd = busSel && !busWrite && atData;
  assign cmdWr = busSel && busWrite && atStatus;
  assign datWr = busSel && busWrite && atData;
  assign padRd = busSel && !busWrite && !atStatus && !atData;

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    padRd |-> busRdata == '0);
  assert_accept_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && enabledFlag && !cmdWr |=> readyFlag);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    datRd && !keyValid |=> !readyFlag);
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enabledFlag && !cmdWr && !datRd |=> $stable(readyFlag));
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && enabledFlag && readyFlag && !datRd && !cmdWr |=> overrunFlag);
  assert_overrun_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    stsRd && !keyValid |=> !overrunFlag);
  assert_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && busWdata == DATA_W'(CMD_ENABLE) |=> enabledFlag);
  assert_selftest_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && busWdata == DATA_W'(CMD_SELFTEST)
    |=> readyFlag && !enabledFlag && !ledPendFlag && !overrunFlag);
  assert_ledset_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && busWdata == DATA_W'(CMD_LEDSET) |=> ledPendFlag);
  assert_led_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(datWr && ledPendFlag) |=> $stable(ledOut));
endmodule

bind scan_port scan_port_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .keyValid(keyValid), .ledOut(ledOut), .readyFlag(readyFlag),
  .overrunFlag(overrunFlag), .enabledFlag(enabledFlag),
  .ledPendFlag(ledPendFlag)
);

// File: tb/scan_port_test.sv
`timescale 1ns/1ps
module scan_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWrite = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       keyValid = 1'b0;
  logic [7:0] keyCode = '0;
  logic [2:0] ledOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] mData;
  bit mReady, mOver, mEn, mPend;
  logic [2:0] mLed;

  always #10 clk = ~clk;  // 50 MHz

  scan_port uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .keyValid(keyValid), .keyCode(keyCode), .ledOut(ledOut)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    if (a == 3'd0) return {4'b0, mPend, mEn, mOver, mReady};
    if (a == 3'd4) return mData;
    return 8'h00;
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    if (a == 3'd0) return "R3";
    if (a == 3'd4) return "R5";
    return "R2";
  endfunction

  task automatic modelStep(input bit s, input bit w, input logic [2:0] a,
                           input logic [7:0] wd, input bit kv, input logic [7:0] kc);
    bit cmdW, dataW, stsR, datR, st, effRdy, acc, drop, load;
    cmdW = s && w && a == 0;  dataW = s && w && a == 4;
    stsR = s && !w && a == 0; datR  = s && !w && a == 4;
    st = cmdW && wd == 8'hAA;
    effRdy = mReady && !datR;
    acc  = kv && mEn && !effRdy && !st;
    drop = kv && mEn && effRdy && !st;
    load = dataW && mPend;
    if (load) mLed = wd[2:0];
    if (st) begin
      mData = 8'h55; mReady = 1; mOver = 0; mEn = 0; mPend = 0;
    end else begin
      if (acc) begin mData = kc; mReady = 1; end
      else if (datR) mReady = 0;
      if (drop) mOver = 1; else if (stsR) mOver = 0;
      if (cmdW && wd == 8'hAE) mEn = 1;
      if (cmdW && wd == 8'hED) mPend = 1; else if (load) mPend = 0;
    end
  endtask

  // one bus cycle: drive at falling edge, compare against model, advance model at rising edge
  task automatic cyc(input bit s, input bit w, input logic [2:0] a, input logic [7:0] wd,
                     input bit kv, input logic [7:0] kc, output logic [7:0] got);
    @(negedge clk);
    busSel = s; busWrite = w; busAddr = a; busWdata = wd; keyValid = kv; keyCode = kc;
    #2;
    got = busRdata;
    if (s && !w) check(got === modelRead(a), tagFor(a), got, modelRead(a));
    check(ledOut === mLed, "R10", {5'b0, ledOut}, {5'b0, mLed});
    @(posedge clk);
    modelStep(s, w, a, wd, kv, kc);
  endtask

  task automatic idle();
    logic [7:0] g;
    cyc(0, 0, 0, 0, 0, 0, g);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] g;
    cyc(1, 0, a, 0, 0, 0, g);
    check(g === exp, tag, g, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] g;
    cyc(1, 1, a, d, 0, 0, g);
  endtask

  task automatic key(input logic [7:0] c);
    logic [7:0] g;
    cyc(0, 0, 0, 0, 1, c, g);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    mData = 0; mReady = 0; mOver = 0; mEn = 0; mPend = 0; mLed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rd(0, 8'h00, "R1");
    check(ledOut === 3'd0, "R1", {5'b0, ledOut}, 8'h00);

    // R6 disabled drops scancodes
    key(8'h1C); idle();
    rd(0, 8'h00, "R6");
    rd(4, 8'h00, "R6");

    // R8 enable, R3 bit 2
    wr(0, 8'hAE); rd(0, 8'h04, "R8");

    // R4 accept, R5 read clears ready
    key(8'h1C); rd(0, 8'h05, "R4");
    rd(4, 8'h1C, "R5"); rd(0, 8'h04, "R5");

    // R7 overrun and clear
    key(8'h32); key(8'h21);
    rd(0, 8'h07, "R7"); rd(0, 8'h05, "R7");
    rd(4, 8'h32, "R7");

    // R5 read and arrival in the same cycle
    key(8'h44);
    cyc(1, 0, 4, 0, 1, 8'h4B, g);
    check(g === 8'h44, "R5", g, 8'h44);
    rd(0, 8'h05, "R5"); rd(4, 8'h4B, "R5");

    // R7 status read collides with a drop: set wins
    key(8'h11);
    cyc(1, 0, 0, 0, 1, 8'h12, g);
    check(g === 8'h05, "R7", g, 8'h05);
    rd(0, 8'h07, "R7"); rd(0, 8'h05, "R7"); rd(4, 8'h11, "R7");

    // R11 data write without pending
    wr(4, 8'h07); idle();
    check(ledOut === 3'd0, "R11", {5'b0, ledOut}, 8'h00);
    rd(0, 8'h04, "R11");

    // R10 LED command then parameter
    wr(0, 8'hED); rd(0, 8'h0C, "R10");
    wr(4, 8'hFE); idle();
    check(ledOut === 3'd6, "R10", {5'b0, ledOut}, 8'h06);
    rd(0, 8'h04, "R10");
    wr(4, 8'h01); idle();
    check(ledOut === 3'd6, "R11", {5'b0, ledOut}, 8'h06);

    // R12 undefined command, R2 pad writes
    wr(0, 8'h12); wr(2, 8'hAA); wr(6, 8'hED);
    rd(0, 8'h04, "R12");
    for (int i = 1; i < 8; i++) if (i != 4) rd(i[2:0], 8'h00, "R2");

    // R9 self-test, arrival in the same cycle discarded
    key(8'h22); key(8'h23);
    cyc(1, 1, 0, 8'hAA, 1, 8'h99, g);
    rd(0, 8'h01, "R9"); key(8'h77);
    rd(4, 8'h55, "R9"); rd(0, 8'h00, "R9");

    // random phase compared with the model each cycle
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? 3'd0 : (pick < 8) ? 3'd4 : 3'($urandom_range(0, 7));
      pick = $urandom_range(0, 5);
      d = (pick == 0) ? 8'hAA : (pick == 1) ? 8'hED : (pick < 4) ? 8'hAE : 8'($urandom);
      if ($urandom_range(0, 19) == 0) d = 8'hAA; else if (d == 8'hAA) d = 8'hAE;
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, d,
          $urandom_range(0, 2) == 0, 8'($urandom), g);
    end
    rd(0, modelRead(0), "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule